// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block is the register front end of a cache maintenance engine that several CPUs drive at once over one simple register bus. Every access carries the issuing CPU's number. A CPU builds a command in a set of shared registers: mode, address, size and way mask. It then reads its own registration-result register, which commits the command into a small in-order queue.

The shared command registers belong to one CPU at a time. The first mode write on a free block claims them. The holder's result read commits the command and releases them. A CPU that tries to claim them while another CPU holds them gets an ownership error. A commit into a full queue gets a full error and the command is dropped. Both errors show in the committing CPU's private result register.

A single executor drains the queue one entry at a time. Each entry takes a fixed number of cycles, and entries run back to back. The executor shows the running entry on its outputs. When an entry that asked for notification finishes, the executor sets an end flag in the issuing CPU's private status register. A sync primitive lets software stall a register read until the queue and the executor are both empty.

Top module: `maint_queue_top`

## Requirements
- R1: After reset no CPU holds the shared registers, the queue is empty, `busReady` is 1, `execBusy` is 0, and every CPU's result (0x25C) and status (0x260) registers read 0.
- R2: A mode write (0x248) while no CPU holds the shared registers gives them to the writer. The holder's next result read returns 0 and queues the command.
- R3: A mode write by a CPU other than the holder leaves the holder's command untouched. That CPU's next result read returns bit 0 = 1, and the read clears the flag, so a second read returns 0.
- R4: A result read by the holder releases the shared registers. A result read by any other CPU with nothing pending returns 0 and does not release them.
- R5: If the queue already holds QUEUE_DEPTH entries when the holder reads its result register, the read returns bit 1 = 1, the command is dropped and the shared registers are released.
- R6: Queued commands start in commit order. Each keeps `execBusy` high for exactly EXEC_LAT cycles, and a waiting entry starts in the cycle after the previous one ends, with `execStart` high for one cycle.
- R7: Mode fields are: command in bits 2:0, notify in bit 15, scope in bits 18:17 (0 = address range), target in bits 22:21 (2 = by way). The executor sees address and size as 0 unless the scope is 0, and the way mask as 0 unless the target is 2.
- R8: When an entry with notify set finishes, bit 2 of its issuing CPU's status register is set, and no other CPU's bit 2 changes. Writing status with bit 2 = 1 clears it; writing 0 leaves it unchanged.
- R9: Status bit 1 reads 1 while the CPU's entry is executing. Bit 0 reads 1 while the CPU has any entry queued or executing.
- R10: Writing 0x8 to the primitive register (0x244) arms a sync. A read of 0x244 then holds `busReady` low until the queue is empty and the executor is idle. Other written values arm nothing.
- R11: Writes to the address (0x24C), size (0x250) or way (0x258) registers by a CPU that does not hold the shared registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busCpu | input | CPU_ID_W | Number of the issuing CPU |
| busAddr | input | 12 | Register offset |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Access accepted this cycle (low only for a stalled sync read) |
| busRdata | output | 32 | Read data, valid in the accepting cycle |
| execBusy | output | 1 | Executor is running an entry |
| execStart | output | 1 | First cycle of a new entry |
| execCpu | output | CPU_ID_W | Issuer of the running entry |
| execOp | output | 3 | Command code of the running entry |
| execTarget | output | 2 | Target field of the running entry |
| execScope | output | 2 | Scope field of the running entry |
| execAddr | output | 32 | Start address (0 unless range scope) |
| execSize | output | 32 | Size (0 unless range scope) |
| execWay | output | WAY_W | Way mask (0 unless target is by way) |

## Verification
A stale or lost owner shows up at the very next result read. A CPU that should be free gets an ownership error, or the holder's commit returns a full flag it should not see. A wrong queue count or pointer shows within one executor window: either the start order or the operand values at the executor outputs differ from the commit order, or the full error appears one entry early or late. A missed or misrouted end flag, or a sync that releases the bus too early, shows in the first status or primitive read after the last busy cycle.

// File: rtl/maint_queue_pkg.sv
package maint_queue_pkg;

  localparam int DATA_W = 32;
  localparam int OFS_W  = 12;

  localparam logic [OFS_W-1:0] OFS_PRIM   = 12'h244;
  localparam logic [OFS_W-1:0] OFS_MODE   = 12'h248;
  localparam logic [OFS_W-1:0] OFS_ADDR   = 12'h24C;
  localparam logic [OFS_W-1:0] OFS_SIZE   = 12'h250;
  localparam logic [OFS_W-1:0] OFS_WAY    = 12'h258;
  localparam logic [OFS_W-1:0] OFS_RESULT = 12'h25C;
  localparam logic [OFS_W-1:0] OFS_STATUS = 12'h260;

  localparam logic [DATA_W-1:0] SYNC_CODE = 32'h8;
  localparam logic [1:0] SCOPE_RANGE = 2'd0;
  localparam logic [1:0] TARGET_WAY  = 2'd2;

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] target;
    logic [1:0] scope;
    logic       notify;
  } modeT;

  typedef struct packed {
    modeT              mode;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] size;
  } entryT;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic syncReq;
    logic clrEnd;
  } strobeT;

  function automatic modeT decodeMode(input logic [DATA_W-1:0] w);
    modeT m;
    m.op     = w[2:0];
    m.notify = w[15];
    m.scope  = w[18:17];
    m.target = w[22:21];
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] encodeMode(input modeT m);
    return {9'd0, m.target, 2'd0, m.scope, 1'b0, m.notify, 12'd0, m.op};
  endfunction

endpackage

// File: rtl/maint_queue_ctrl.sv
module maint_queue_ctrl
  import maint_queue_pkg::*;
#(
  parameter int NUM_CPU  = 4,
  parameter int CPU_ID_W = 2,
  parameter int WAY_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [CPU_ID_W-1:0] busCpu,
  input  logic [OFS_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic                busReady,
  output logic [DATA_W-1:0]   busRdata,
  input  logic                fifoFull,
  input  logic                syncBusy,
  input  logic [NUM_CPU-1:0]  endFlag,
  input  logic [NUM_CPU-1:0]  queuedMask,
  input  logic [NUM_CPU-1:0]  execMask,
  output strobeT              strobe,
  output entryT               pushEntry,
  output logic [WAY_W-1:0]    pushWay
);

  logic                ownerValid;
  logic [CPU_ID_W-1:0] ownerCpu;
  modeT                modeReg;
  logic [DATA_W-1:0]   addrReg;
  logic [DATA_W-1:0]   sizeReg;
  logic [WAY_W-1:0]    wayReg;
  logic [NUM_CPU-1:0]  errOe;

  logic isRead, wrAcc, rdAcc, isOwner;

  assign isRead   = busValid && !busWrite;
  assign busReady = !(isRead && busAddr == OFS_PRIM && syncBusy);
  assign wrAcc    = busValid && busWrite && busReady;
  assign rdAcc    = isRead && busReady;
  assign isOwner  = ownerValid && (busCpu == ownerCpu);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerValid <= 1'b0;
      ownerCpu   <= '0;
      modeReg    <= '0;
      addrReg    <= '0;
      sizeReg    <= '0;
      wayReg     <= '0;
      errOe      <= '0;
    end else begin
      if (wrAcc) begin
        unique case (busAddr)
          OFS_MODE: begin
            if (!ownerValid) begin
              ownerValid <= 1'b1;
              ownerCpu   <= busCpu;
              modeReg    <= decodeMode(busWdata);
            end else if (isOwner) begin
              modeReg <= decodeMode(busWdata);
            end else begin
              errOe[busCpu] <= 1'b1;
            end
          end
          OFS_ADDR: if (isOwner) addrReg <= busWdata;
          OFS_SIZE: if (isOwner) sizeReg <= busWdata;
          OFS_WAY:  if (isOwner) wayReg  <= busWdata[WAY_W-1:0];
          default: ;
        endcase
      end
      if (rdAcc && busAddr == OFS_RESULT) begin
        errOe[busCpu] <= 1'b0;
        if (isOwner) ownerValid <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.push    = rdAcc && busAddr == OFS_RESULT && isOwner && !fifoFull;
    strobe.syncReq = wrAcc && busAddr == OFS_PRIM && busWdata == SYNC_CODE;
    strobe.clrEnd  = wrAcc && busAddr == OFS_STATUS && busWdata[2];
  end

  // Operands that the scope or target does not use are cleared at commit
  always_comb begin
    pushEntry.mode = modeReg;
    pushEntry.addr = (modeReg.scope == SCOPE_RANGE) ? addrReg : '0;
    pushEntry.size = (modeReg.scope == SCOPE_RANGE) ? sizeReg : '0;
    pushWay        = (modeReg.target == TARGET_WAY) ? wayReg : '0;
  end

  always_comb begin
    busRdata = '0;
    if (isRead) begin
      unique case (busAddr)
        OFS_MODE:   busRdata = encodeMode(modeReg);
        OFS_ADDR:   busRdata = addrReg;
        OFS_SIZE:   busRdata = sizeReg;
        OFS_WAY:    busRdata = {{(DATA_W-WAY_W){1'b0}}, wayReg};
        OFS_RESULT: busRdata = {{(DATA_W-2){1'b0}}, isOwner && fifoFull, errOe[busCpu]};
        OFS_STATUS: busRdata = {{(DATA_W-3){1'b0}}, endFlag[busCpu],
                                execMask[busCpu], queuedMask[busCpu]};
        default:    busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/maint_queue_dpath.sv
module maint_queue_dpath
  import maint_queue_pkg::*;
#(
  parameter int NUM_CPU     = 4,
  parameter int CPU_ID_W    = 2,
  parameter int WAY_W       = 8,
  parameter int QUEUE_DEPTH = 4,
  parameter int EXEC_LAT    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic [CPU_ID_W-1:0] strobeCpu,
  input  entryT               pushEntry,
  input  logic [WAY_W-1:0]    pushWay,
  output logic                fifoFull,
  output logic                syncBusy,
  output logic [NUM_CPU-1:0]  endFlag,
  output logic [NUM_CPU-1:0]  queuedMask,
  output logic [NUM_CPU-1:0]  execMask,
  output logic                execBusy,
  output logic                execStart,
  output logic [CPU_ID_W-1:0] execCpu,
  output entryT               execEntry,
  output logic [WAY_W-1:0]    execWay
);

  localparam int PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);
  localparam int LAT_W = $clog2(EXEC_LAT + 1);

  entryT               entryMem [QUEUE_DEPTH];
  logic [WAY_W-1:0]    wayMem   [QUEUE_DEPTH];
  logic [CPU_ID_W-1:0] cpuMem   [QUEUE_DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0]    count;
  logic [LAT_W-1:0]    remain;
  logic                syncPend;
  logic                finishing, pop, push;
  logic [NUM_CPU-1:0]  queuedRaw;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (int'(p) == QUEUE_DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign fifoFull  = (int'(count) == QUEUE_DEPTH);
  assign push      = strobe.push && !fifoFull;
  assign finishing = execBusy && (remain == LAT_W'(1));
  assign pop       = (count != '0) && (!execBusy || finishing);
  assign syncBusy  = syncPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        entryMem[wrPtr] <= pushEntry;
        wayMem[wrPtr]   <= pushWay;
        cpuMem[wrPtr]   <= strobeCpu;
        wrPtr           <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // Executor: fixed countdown, chained to the next entry without a gap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      execBusy  <= 1'b0;
      execStart <= 1'b0;
      remain    <= '0;
      execCpu   <= '0;
      execEntry <= '0;
      execWay   <= '0;
    end else begin
      execStart <= 1'b0;
      if (pop) begin
        execBusy  <= 1'b1;
        execStart <= 1'b1;
        remain    <= LAT_W'(EXEC_LAT);
        execCpu   <= cpuMem[rdPtr];
        execEntry <= entryMem[rdPtr];
        execWay   <= wayMem[rdPtr];
      end else if (finishing) begin
        execBusy <= 1'b0;
      end else if (execBusy) begin
        remain <= remain - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncPend <= 1'b0;
    else if (strobe.syncReq) syncPend <= 1'b1;
    else if (count == '0 && !execBusy) syncPend <= 1'b0;
  end

  always_comb begin
    queuedRaw = '0;
    for (int k = 0; k < QUEUE_DEPTH; k++) begin
      int idx;
      idx = int'(rdPtr) + k;
      if (idx >= QUEUE_DEPTH) idx = idx - QUEUE_DEPTH;
      if (k < int'(count)) queuedRaw[cpuMem[idx]] = 1'b1;
    end
  end

  assign queuedMask = queuedRaw | execMask;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign execMask[c] = execBusy && (execCpu == CPU_ID_W'(c));

    always_ff @(posedge clk) begin
      if (!rstN) endFlag[c] <= 1'b0;
      else if (finishing && execEntry.mode.notify && execCpu == CPU_ID_W'(c))
        endFlag[c] <= 1'b1;
      else if (strobe.clrEnd && strobeCpu == CPU_ID_W'(c))
        endFlag[c] <= 1'b0;
    end
  end

endmodule

// File: rtl/maint_queue_top.sv
module maint_queue_top
  import maint_queue_pkg::*;
#(
  parameter int NUM_CPU     = 4,
  parameter int QUEUE_DEPTH = 4,
  parameter int EXEC_LAT    = 6,
  parameter int WAY_W       = 8,
  localparam int CPU_ID_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [CPU_ID_W-1:0] busCpu,
  input  logic [11:0]         busAddr,
  input  logic [31:0]         busWdata,
  output logic                busReady,
  output logic [31:0]         busRdata,
  output logic                execBusy,
  output logic                execStart,
  output logic [CPU_ID_W-1:0] execCpu,
  output logic [2:0]          execOp,
  output logic [1:0]          execTarget,
  output logic [1:0]          execScope,
  output logic [31:0]         execAddr,
  output logic [31:0]         execSize,
  output logic [WAY_W-1:0]    execWay
);

  strobeT             strobe;
  entryT              pushEntry, execEntry;
  logic [WAY_W-1:0]   pushWay;
  logic               fifoFull, syncBusy;
  logic [NUM_CPU-1:0] endFlag, queuedMask, execMask;

  maint_queue_ctrl #(
    .NUM_CPU(NUM_CPU), .CPU_ID_W(CPU_ID_W), .WAY_W(WAY_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busCpu(busCpu),
    .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata),
    .fifoFull(fifoFull), .syncBusy(syncBusy), .endFlag(endFlag),
    .queuedMask(queuedMask), .execMask(execMask),
    .strobe(strobe), .pushEntry(pushEntry), .pushWay(pushWay)
  );

  maint_queue_dpath #(
    .NUM_CPU(NUM_CPU), .CPU_ID_W(CPU_ID_W), .WAY_W(WAY_W),
    .QUEUE_DEPTH(QUEUE_DEPTH), .EXEC_LAT(EXEC_LAT)
  ) i_dpath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .strobeCpu(busCpu),
    .pushEntry(pushEntry), .pushWay(pushWay),
    .fifoFull(fifoFull), .syncBusy(syncBusy), .endFlag(endFlag),
    .queuedMask(queuedMask), .execMask(execMask),
    .execBusy(execBusy), .execStart(execStart), .execCpu(execCpu),
    .execEntry(execEntry), .execWay(execWay)
  );

  assign execOp     = execEntry.mode.op;
  assign execTarget = execEntry.mode.target;
  assign execScope  = execEntry.mode.scope;
  assign execAddr   = execEntry.addr;
  assign execSize   = execEntry.size;

endmodule

// File: rtl/maint_queue_checker.sv
module maint_queue_checker #(
  parameter int EXEC_LAT = 6,
  parameter int WAY_W    = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic             busWrite,
  input logic [11:0]      busAddr,
  input logic             busReady,
  input logic             execBusy,
  input logic             execStart,
  input logic [1:0]       execTarget,
  input logic [1:0]       execScope,
  input logic [31:0]      execAddr,
  input logic [31:0]      execSize,
  input logic [WAY_W-1:0] execWay
);

  logic [31:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else if (execStart) runCnt <= 32'd1;
    else if (execBusy) runCnt <= runCnt + 32'd1;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    execStart |-> execBusy); // R6
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (execBusy && !execStart) |-> runCnt < EXEC_LAT); // R6
  AST_RUN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(execBusy) |-> runCnt == EXEC_LAT); // R6
  AST_CHAIN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (execStart && $past(execBusy)) |-> runCnt == EXEC_LAT); // R6
  AST_RANGE_OPERANDS: assert property (@(posedge clk) disable iff (!rstN)
    (execBusy && execScope != 2'd0) |-> (execAddr == '0 && execSize == '0)); // R7
  AST_WAY_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    (execBusy && execTarget != 2'd2) |-> execWay == '0); // R7
  AST_STALL_SYNC_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |-> (busValid && !busWrite && busAddr == 12'h244)); // R10

endmodule

bind maint_queue_top maint_queue_checker #(.EXEC_LAT(EXEC_LAT), .WAY_W(WAY_W)) i_chk (.*);

// File: tb/test_maint_queue_top.sv
module test_maint_queue_top;

  localparam int NCPU = 4;
  localparam int DEPTH = 4;
  localparam int LAT = 24;
  localparam int WW = 8;

  localparam logic [11:0] A_PRIM = 12'h244, A_MODE = 12'h248, A_ADDR = 12'h24C,
                          A_SIZE = 12'h250, A_WAY = 12'h258, A_RES = 12'h25C,
                          A_STAT = 12'h260;

  logic clk = 1'b0, rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [1:0] busCpu = '0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busReady, execBusy, execStart;
  logic [31:0] busRdata, execAddr, execSize;
  logic [1:0] execCpu, execTarget, execScope;
  logic [2:0] execOp;
  logic [WW-1:0] execWay;

  int checks = 0, fails = 0, cyc = 0, logN = 0;
  bit finished = 1'b0;
  int logCpu[64], logOp[64], logCyc[64];
  logic [31:0] logAddr[64], logSize[64], logWay[64];

  always #2 clk = ~clk;

  maint_queue_top #(.NUM_CPU(NCPU), .QUEUE_DEPTH(DEPTH), .EXEC_LAT(LAT), .WAY_W(WW))
    i_maint_queue_top (.*);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (execStart && logN < 64) begin
      logCpu[logN] = execCpu; logOp[logN] = execOp; logCyc[logN] = cyc;
      logAddr[logN] = execAddr; logSize[logN] = execSize;
      logWay[logN] = 32'(execWay);
      logN = logN + 1;
    end
  end

  function automatic logic [31:0] mk(int op, int tgt, int scp, bit ntf);
    return (32'(tgt) << 21) | (32'(scp) << 17) | (32'(ntf) << 15) | 32'(op);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busCpu = 2'(cpu); busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d, output int stalls);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busCpu = 2'(cpu); busAddr = a;
    stalls = 0;
    forever begin
      #1;
      if (busReady) begin
        d = busRdata;
        @(posedge clk);
        break;
      end
      stalls++;
      @(negedge clk);
    end
    #1 busValid = 1'b0;
  endtask

  function automatic int rdv_dummy(); return 0; endfunction

  initial begin : watchdog
    #(4 * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int st, base;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    check("R1 ready", 32'(busReady), 1);
    check("R1 busy", 32'(execBusy), 0);
    for (int c = 0; c < NCPU; c++) begin
      rd(c, A_RES, v, st);  check("R1 result", v, 0);
      rd(c, A_STAT, v, st); check("R1 status", v, 0);
    end

    // R2 R7 R8: single notified range command, way dropped (target LRU data)
    base = logN;
    wr(0, A_MODE, mk(1, 0, 0, 1));
    wr(0, A_ADDR, 32'h1000);
    wr(0, A_SIZE, 32'h40);
    wr(0, A_WAY, 32'h5);
    rd(0, A_RES, v, st); check("R2 commit result", v, 0);
    repeat (LAT + 4) @(posedge clk);
    check("R2 started", 32'(logN - base), 1);
    check("R2 cpu", 32'(logCpu[base]), 0);
    check("R2 op", 32'(logOp[base]), 1);
    check("R7 range addr kept", logAddr[base], 32'h1000);
    check("R7 range size kept", logSize[base], 32'h40);
    check("R7 way dropped", logWay[base], 0);
    rd(0, A_STAT, v, st); check("R8 end flag set", v, 4);
    rd(1, A_STAT, v, st); check("R8 other cpu untouched", v, 0);
    wr(0, A_STAT, 0);
    rd(0, A_STAT, v, st); check("R8 write 0 keeps", v, 4);
    wr(0, A_STAT, 4);
    rd(0, A_STAT, v, st); check("R8 write 1 clears", v, 0);

    // R3 R4 R11: ownership conflict
    base = logN;
    wr(1, A_MODE, mk(0, 0, 0, 0));
    wr(1, A_ADDR, 32'h2000);
    wr(1, A_SIZE, 32'h80);
    wr(2, A_MODE, mk(2, 0, 0, 0));
    wr(2, A_ADDR, 32'hDEAD0);
    wr(2, A_SIZE, 32'h999);
    rd(3, A_RES, v, st); check("R4 non-holder read zero", v, 0);
    wr(3, A_MODE, mk(3, 0, 1, 0));
    rd(3, A_RES, v, st); check("R3 holder kept after other read", v, 1);
    rd(1, A_RES, v, st); check("R2 holder commit", v, 0);
    rd(2, A_RES, v, st); check("R3 ownership error", v, 1);
    rd(2, A_RES, v, st); check("R3 error cleared", v, 0);
    wr(3, A_MODE, mk(4, 0, 1, 0));
    rd(3, A_RES, v, st); check("R4 released after holder read", v, 0);
    repeat (2 * LAT + 4) @(posedge clk);
    check("R6 two started", 32'(logN - base), 2);
    check("R11 addr unchanged", logAddr[base], 32'h2000);
    check("R11 size unchanged", logSize[base], 32'h80);
    check("R6 order second cpu", 32'(logCpu[base + 1]), 3);
    check("R7 all scope addr zero", logAddr[base + 1], 0);

    // R5 R6 R9: fill the queue
    base = logN;
    wr(0, A_MODE, mk(0, 0, 1, 0));  rd(0, A_RES, v, st);
    wr(1, A_MODE, mk(1, 2, 1, 0));  wr(1, A_WAY, 32'h5A); wr(1, A_ADDR, 32'h777);
    rd(1, A_RES, v, st);
    wr(2, A_MODE, mk(2, 0, 1, 1));  rd(2, A_RES, v, st);
    wr(1, A_MODE, mk(3, 0, 1, 0));  rd(1, A_RES, v, st);
    wr(2, A_MODE, mk(4, 0, 1, 0));  rd(2, A_RES, v, st);
    check("R2 last fitting commit", v, 0);
    wr(3, A_MODE, mk(5, 0, 1, 0));  rd(3, A_RES, v, st);
    check("R5 full error", v, 2);
    wr(1, A_MODE, mk(6, 0, 1, 0));  rd(1, A_RES, v, st);
    check("R5 released after full", v, 2);
    rd(0, A_STAT, v, st); check("R9 executing cpu", v, 3);
    rd(1, A_STAT, v, st); check("R9 queued cpu1", v, 1);
    rd(2, A_STAT, v, st); check("R9 queued cpu2", v, 1);
    rd(3, A_STAT, v, st); check("R9 dropped cpu3", v, 0);
    repeat (5 * LAT + 8) @(posedge clk);
    check("R5 dropped commands absent", 32'(logN - base), 5);
    for (int i = 0; i < 5; i++) begin
      check("R6 order op", 32'(logOp[base + i]), 32'(i));
      if (i > 0) check("R6 spacing", 32'(logCyc[base + i] - logCyc[base + i - 1]), LAT);
    end
    check("R6 order cpu", 32'(logCpu[base + 3]), 1);
    check("R7 way kept", logWay[base + 1], 32'h5A);
    check("R7 all scope addr", logAddr[base + 1], 0);
    rd(2, A_STAT, v, st); check("R8 notified cpu2", v, 4);
    rd(1, A_STAT, v, st); check("R8 cpu1 no notify", v, 0);
    wr(2, A_STAT, 4);

    // R10: sync drains, other codes do not
    wr(0, A_MODE, mk(2, 0, 1, 0)); rd(0, A_RES, v, st);
    wr(0, A_PRIM, 32'h8);
    rd(0, A_PRIM, v, st);
    check("R10 sync stalled", 32'(st >= LAT - 4), 1);
    check("R10 drained", 32'(execBusy), 0);
    rd(0, A_STAT, v, st); check("R10 queue empty", v, 0);
    wr(0, A_MODE, mk(2, 0, 1, 0)); rd(0, A_RES, v, st);
    wr(0, A_PRIM, 32'h3);
    rd(0, A_PRIM, v, st);
    check("R10 non-sync no stall", 32'(st), 0);
    check("R10 still busy", 32'(execBusy), 1);
    repeat (LAT + 4) @(posedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule